// File: doc/BRIEF.md
# Dual-Channel UART Host Register Interface

This block is the processor-facing register front end of a two-channel serial port. A single 8-bit host bus with three address lines, an active-low select, a channel-select line and active-low read and write strobes reaches two independent register banks. The channel-select level picks the bank. Each bank holds its own line-control byte, so each bank has its own divisor-access flag. That flag is the top bit of the line-control byte. While it is set, the three lowest addresses of that bank reach the two divisor bytes and an alternate-function byte instead of the normal registers.

The strobes and bus fields are asynchronous to the block clock. They are passed through a synchroniser and their edges are detected, so every register update happens in the clock domain. A write takes effect on the detected rising edge of the write strobe, using the address, channel and data that were present while the strobe was low. Read data is registered and comes out on a data output with a separate drive-enable. The pad ring merges these into the three-state bus. Read-only values (receive buffer, interrupt identification, line status, modem status) come in from the neighbouring serial, FIFO and interrupt logic. Writes to the transmit-holding address produce a one-cycle pulse toward the transmitter.

Top module: `duart_host_if`

## Requirements
- R1: While reset is high, and on the first cycle after it, every configuration output is zero, the transmit pulses are low and the data drive-enable is low.
- R2: With channel select at 1 an access reaches bank 0 (output index 0). With channel select at 0 it reaches bank 1 (output index 1). A write to one bank leaves the other bank's registers unchanged.
- R3: With the bank's flag clear, writes to address 1 set the interrupt-enable byte, address 2 the FIFO-control byte, address 3 the line-control byte, address 4 the modem-control byte and address 7 the scratch byte. Each written value appears on the matching output.
- R4: With the bank's flag set, writes to address 0 set the divisor low byte, address 1 the divisor high byte and address 2 the alternate-function byte. The interrupt-enable and FIFO-control bytes are left unchanged.
- R5: The divisor-access flag is bit 7 of each bank's own line-control byte. Setting it in one bank does not change how addresses of the other bank decode.
- R6: A write commits only after the write strobe returns high. While the strobe is held low, the target register keeps its old value.
- R7: With chip select high, a write strobe changes no register and a read strobe leaves the drive-enable low.
- R8: During a read with chip select low, the drive-enable is high and the data output carries the selected value. Flag clear: 0 receive buffer, 1 interrupt enable, 2 interrupt identification, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch. Flag set: 0, 1 and 2 give divisor low, divisor high and alternate function. The drive-enable drops after the strobe rises.
- R9: A write to address 0 with the flag clear produces exactly one one-cycle transmit pulse on that bank, with the written byte on that bank's transmit data output. With the flag set, no pulse is produced.
- R10: With the read strobe high, the drive-enable stays low even while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ch_sel | input | 1 | Channel select: 1 = bank 0, 0 = bank 1 |
| addr_i | input | 3 | Register address |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| data_i | input | 8 | Bus data from host |
| data_o | output | 8 | Registered read data toward the pad |
| data_oe | output | 1 | Pad drive-enable for read data |
| rbr_i | input | 2x8 | Receive buffer value per bank |
| iir_i | input | 2x8 | Interrupt identification value per bank |
| lsr_i | input | 2x8 | Line status value per bank |
| msr_i | input | 2x8 | Modem status value per bank |
| ier_o | output | 2x8 | Interrupt-enable byte per bank |
| fcr_o | output | 2x8 | FIFO-control byte per bank |
| lcr_o | output | 2x8 | Line-control byte per bank |
| mcr_o | output | 2x8 | Modem-control byte per bank |
| dll_o | output | 2x8 | Divisor low byte per bank |
| dlm_o | output | 2x8 | Divisor high byte per bank |
| afr_o | output | 2x8 | Alternate-function byte per bank |
| thr_wr_o | output | 2 | One-cycle transmit-holding write pulse per bank |
| thr_data_o | output | 2x8 | Transmit byte per bank |

## Verification
A sequence of writes and read-backs first fills both banks with different scratch and control values, then reads them back in an interleaved order. A swapped channel mapping therefore shows up as a wrong byte. The sequence then sets the divisor flag in one bank only and reads the low addresses of both banks. This separates a per-bank flag from a shared one, and divisor storage from the interrupt-enable and FIFO-control bytes. Every read-only address uses distinct values per bank, which catches address-decode slips. Directed cases hold the write strobe low for a long time, strobe with chip select high, strobe the read line while chip select is low, and write the transmit address with and without the flag.

// File: rtl/duart_pkg.sv
package duart_pkg;

  localparam int ADDR_W = 3;
  localparam int NUM_CH = 2;

  typedef enum logic [3:0] {
    SEL_RBR_THR,
    SEL_IER,
    SEL_IIR_FCR,
    SEL_LCR,
    SEL_MCR,
    SEL_LSR,
    SEL_MSR,
    SEL_SCR,
    SEL_DLL,
    SEL_DLM,
    SEL_AFR
  } reg_sel_e;

  // Address decode: the divisor-access flag redirects the three low addresses.
  function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a, input logic dlab);
    reg_sel_e s;
    case (a)
      3'd0:    s = dlab ? SEL_DLL : SEL_RBR_THR;
      3'd1:    s = dlab ? SEL_DLM : SEL_IER;
      3'd2:    s = dlab ? SEL_AFR : SEL_IIR_FCR;
      3'd3:    s = SEL_LCR;
      3'd4:    s = SEL_MCR;
      3'd5:    s = SEL_LSR;
      3'd6:    s = SEL_MSR;
      default: s = SEL_SCR;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/duart_bus_sync.sv
module duart_bus_sync #(
  parameter int              W      = 8,
  parameter int              STAGES = 2,
  parameter logic [W-1:0]    IDLE   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);

  logic [W-1:0] pipe [STAGES];

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= IDLE;
          else     pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[k] <= IDLE;
          else     pipe[k] <= pipe[k-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q_prev <= IDLE;
    else     q_prev <= pipe[STAGES-1];
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/duart_chan_regs.sv
module duart_chan_regs
  import duart_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  reg_sel_e      sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ier,
  output logic [DW-1:0] fcr,
  output logic [DW-1:0] lcr,
  output logic [DW-1:0] mcr,
  output logic [DW-1:0] scr,
  output logic [DW-1:0] dll,
  output logic [DW-1:0] dlm,
  output logic [DW-1:0] afr,
  output logic          thr_wr,
  output logic [DW-1:0] thr_data,
  output logic          dlab
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ier      <= '0;
      fcr      <= '0;
      lcr      <= '0;
      mcr      <= '0;
      scr      <= '0;
      dll      <= '0;
      dlm      <= '0;
      afr      <= '0;
      thr_wr   <= 1'b0;
      thr_data <= '0;
    end else begin
      thr_wr <= 1'b0;
      if (wr_en) begin
        case (sel)
          SEL_RBR_THR: begin
            thr_wr   <= 1'b1;
            thr_data <= wdata;
          end
          SEL_IER:     ier <= wdata;
          SEL_IIR_FCR: fcr <= wdata;
          SEL_LCR:     lcr <= wdata;
          SEL_MCR:     mcr <= wdata;
          SEL_SCR:     scr <= wdata;
          SEL_DLL:     dll <= wdata;
          SEL_DLM:     dlm <= wdata;
          SEL_AFR:     afr <= wdata;
          default:     ;
        endcase
      end
    end
  end

  assign dlab = lcr[DW-1];

endmodule

// File: rtl/duart_rd_path.sv
module duart_rd_path
  import duart_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     active,
  input  logic                     bank,
  input  reg_sel_e                 sel,
  input  logic [NUM_CH-1:0][DW-1:0] rbr,
  input  logic [NUM_CH-1:0][DW-1:0] iir,
  input  logic [NUM_CH-1:0][DW-1:0] lsr,
  input  logic [NUM_CH-1:0][DW-1:0] msr,
  input  logic [NUM_CH-1:0][DW-1:0] ier,
  input  logic [NUM_CH-1:0][DW-1:0] lcr,
  input  logic [NUM_CH-1:0][DW-1:0] mcr,
  input  logic [NUM_CH-1:0][DW-1:0] scr,
  input  logic [NUM_CH-1:0][DW-1:0] dll,
  input  logic [NUM_CH-1:0][DW-1:0] dlm,
  input  logic [NUM_CH-1:0][DW-1:0] afr,
  output logic [DW-1:0]            dout,
  output logic                     oe
);

  logic [DW-1:0] mux;

  always_comb begin
    case (sel)
      SEL_RBR_THR: mux = rbr[bank];
      SEL_IER:     mux = ier[bank];
      SEL_IIR_FCR: mux = iir[bank];
      SEL_LCR:     mux = lcr[bank];
      SEL_MCR:     mux = mcr[bank];
      SEL_LSR:     mux = lsr[bank];
      SEL_MSR:     mux = msr[bank];
      SEL_SCR:     mux = scr[bank];
      SEL_DLL:     mux = dll[bank];
      SEL_DLM:     mux = dlm[bank];
      SEL_AFR:     mux = afr[bank];
      default:     mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      oe   <= 1'b0;
    end else begin
      oe <= active;
      if (active) dout <= mux;
    end
  end

endmodule

// File: rtl/duart_host_if.sv
module duart_host_if
  import duart_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cs_n,
  input  logic                          ch_sel,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          rd_n,
  input  logic                          wr_n,
  input  logic [DATA_W-1:0]             data_i,
  output logic [DATA_W-1:0]             data_o,
  output logic                          data_oe,
  input  logic [NUM_CH-1:0][DATA_W-1:0] rbr_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0] iir_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0] lsr_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0] msr_i,
  output logic [NUM_CH-1:0][DATA_W-1:0] ier_o,
  output logic [NUM_CH-1:0][DATA_W-1:0] fcr_o,
  output logic [NUM_CH-1:0][DATA_W-1:0] lcr_o,
  output logic [NUM_CH-1:0][DATA_W-1:0] mcr_o,
  output logic [NUM_CH-1:0][DATA_W-1:0] dll_o,
  output logic [NUM_CH-1:0][DATA_W-1:0] dlm_o,
  output logic [NUM_CH-1:0][DATA_W-1:0] afr_o,
  output logic [NUM_CH-1:0]             thr_wr_o,
  output logic [NUM_CH-1:0][DATA_W-1:0] thr_data_o
);

  // Packed bus sample: {cs_n, rd_n, wr_n, ch_sel, addr, data}
  localparam int PW = 4 + ADDR_W + DATA_W;
  localparam logic [PW-1:0] IDLE = {3'b111, {(PW-3){1'b0}}};
  localparam int P_CS = PW - 1;
  localparam int P_RD = PW - 2;
  localparam int P_WR = PW - 3;
  localparam int P_CH = PW - 4;

  logic [PW-1:0] bus_raw, cur, prv;

  assign bus_raw = {cs_n, rd_n, wr_n, ch_sel, addr_i, data_i};

  duart_bus_sync #(.W(PW), .STAGES(SYNC_STAGES), .IDLE(IDLE)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d      (bus_raw),
    .q      (cur),
    .q_prev (prv)
  );

  // Write side: commit on the synchronised rising edge of the write strobe,
  // using the fields captured while the strobe was still low.
  logic                wr_commit;
  logic                wbank;
  logic [ADDR_W-1:0]   waddr;
  logic [DATA_W-1:0]   wdata;
  logic [NUM_CH-1:0]   dlab;
  logic [NUM_CH-1:0][DATA_W-1:0] scr_q;
  reg_sel_e            wsel;

  assign wr_commit = !prv[P_WR] && cur[P_WR] && !prv[P_CS];
  assign wbank     = ~prv[P_CH];
  assign waddr     = prv[DATA_W +: ADDR_W];
  assign wdata     = prv[DATA_W-1:0];
  assign wsel      = decode_sel(waddr, dlab[wbank]);

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_bank
      duart_chan_regs #(.DW(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_commit && (wbank == 1'(g))),
        .sel      (wsel),
        .wdata    (wdata),
        .ier      (ier_o[g]),
        .fcr      (fcr_o[g]),
        .lcr      (lcr_o[g]),
        .mcr      (mcr_o[g]),
        .scr      (scr_q[g]),
        .dll      (dll_o[g]),
        .dlm      (dlm_o[g]),
        .afr      (afr_o[g]),
        .thr_wr   (thr_wr_o[g]),
        .thr_data (thr_data_o[g]),
        .dlab     (dlab[g])
      );
    end
  endgenerate

  // Read side: decode from the current synchronised sample.
  logic     rd_active;
  logic     rbank;
  reg_sel_e rsel;

  assign rd_active = !cur[P_RD] && !cur[P_CS];
  assign rbank     = ~cur[P_CH];
  assign rsel      = decode_sel(cur[DATA_W +: ADDR_W], dlab[rbank]);

  duart_rd_path #(.DW(DATA_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .active (rd_active),
    .bank   (rbank),
    .sel    (rsel),
    .rbr    (rbr_i),
    .iir    (iir_i),
    .lsr    (lsr_i),
    .msr    (msr_i),
    .ier    (ier_o),
    .lcr    (lcr_o),
    .mcr    (mcr_o),
    .scr    (scr_q),
    .dll    (dll_o),
    .dlm    (dlm_o),
    .afr    (afr_o),
    .dout   (data_o),
    .oe     (data_oe)
  );

endmodule

// File: rtl/duart_host_if_chk.sv
module duart_host_if_chk #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                cs_n,
  input logic                rd_n,
  input logic                wr_n,
  input logic                data_oe,
  input logic [1:0]          thr_wr,
  input logic [1:0][DW-1:0]  lcr
);

  localparam int QUIET = SYNC_STAGES + 3;

  logic [7:0] wr_idle;
  logic [7:0] rd_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idle <= '0;
      rd_idle <= '0;
    end else begin
      if (!wr_n)                wr_idle <= '0;
      else if (wr_idle != 8'hFF) wr_idle <= wr_idle + 8'd1;
      if (!rd_n && !cs_n)       rd_idle <= '0;
      else if (rd_idle != 8'hFF) rd_idle <= rd_idle + 8'd1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (lcr == '0 && !data_oe && thr_wr == '0)); // R1
  AST_THR_ONE_BANK: assert property (@(posedge clk) disable iff (rst) $onehot0(thr_wr)); // R2
  AST_NO_EARLY_COMMIT: assert property (@(posedge clk) disable iff (rst) (wr_idle >= 8'(QUIET)) |-> $stable(lcr)); // R6
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst) (rd_idle >= 8'(QUIET)) |-> !data_oe); // R10
  AST_THR_SINGLE: assert property (@(posedge clk) disable iff (rst) (thr_wr != 2'b00) |=> (thr_wr == 2'b00)); // R9

endmodule

bind duart_host_if duart_host_if_chk #(.DW(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_n    (cs_n),
  .rd_n    (rd_n),
  .wr_n    (wr_n),
  .data_oe (data_oe),
  .thr_wr  (thr_wr_o),
  .lcr     (lcr_o)
);

// File: tb/duart_host_if_tb.sv
module duart_host_if_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic            cs_n = 1'b1, ch_sel = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0]      addr_i = '0;
  logic [7:0]      data_i = '0;
  logic [7:0]      data_o;
  logic            data_oe;
  logic [1:0][7:0] rbr_i, iir_i, lsr_i, msr_i;
  logic [1:0][7:0] ier_o, fcr_o, lcr_o, mcr_o, dll_o, dlm_o, afr_o, thr_data_o;
  logic [1:0]      thr_wr_o;

  assign rbr_i = {8'h21, 8'h11};
  assign iir_i = {8'hC2, 8'hC1};
  assign lsr_i = {8'h61, 8'h60};
  assign msr_i = {8'h31, 8'h30};

  duart_host_if u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ch_sel(ch_sel), .addr_i(addr_i),
    .rd_n(rd_n), .wr_n(wr_n), .data_i(data_i), .data_o(data_o), .data_oe(data_oe),
    .rbr_i(rbr_i), .iir_i(iir_i), .lsr_i(lsr_i), .msr_i(msr_i),
    .ier_o(ier_o), .fcr_o(fcr_o), .lcr_o(lcr_o), .mcr_o(mcr_o),
    .dll_o(dll_o), .dlm_o(dlm_o), .afr_o(afr_o),
    .thr_wr_o(thr_wr_o), .thr_data_o(thr_data_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int thr_cnt0 = 0;
  int thr_cnt1 = 0;

  always @(posedge clk) begin
    if (!rst) begin
      if (thr_wr_o[0]) thr_cnt0++;
      if (thr_wr_o[1]) thr_cnt1++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic ch, input logic [2:0] a, input logic [7:0] d,
                           input logic sel_chip, input int hold);
    @(negedge clk);
    cs_n = ~sel_chip; ch_sel = ch; addr_i = a; data_i = d;
    repeat (2) @(negedge clk);
    wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    wr_n = 1'b1;
    repeat (5) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_read(input logic ch, input logic [2:0] a, input logic sel_chip,
                          output logic [7:0] val, output logic oe_on, output logic oe_off);
    @(negedge clk);
    cs_n = ~sel_chip; ch_sel = ch; addr_i = a;
    repeat (2) @(negedge clk);
    rd_n = 1'b0;
    repeat (5) @(negedge clk);
    val = data_o; oe_on = data_oe;
    rd_n = 1'b1;
    repeat (5) @(negedge clk);
    oe_off = data_oe;
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // {is_write, ch_sel, addr, data, expected read}
  localparam int NV = 29;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 1'b1, 3'd3, 8'h03, 8'h00},
    {1'b1, 1'b1, 3'd1, 8'h0F, 8'h00},
    {1'b1, 1'b1, 3'd7, 8'hA5, 8'h00},
    {1'b1, 1'b0, 3'd7, 8'h5A, 8'h00},
    {1'b0, 1'b1, 3'd7, 8'h00, 8'hA5},
    {1'b0, 1'b0, 3'd7, 8'h00, 8'h5A},
    {1'b0, 1'b1, 3'd1, 8'h00, 8'h0F},
    {1'b0, 1'b0, 3'd1, 8'h00, 8'h00},
    {1'b1, 1'b1, 3'd3, 8'h83, 8'h00},
    {1'b1, 1'b1, 3'd0, 8'h34, 8'h00},
    {1'b1, 1'b1, 3'd1, 8'h12, 8'h00},
    {1'b1, 1'b1, 3'd2, 8'h07, 8'h00},
    {1'b0, 1'b1, 3'd0, 8'h00, 8'h34},
    {1'b0, 1'b1, 3'd1, 8'h00, 8'h12},
    {1'b0, 1'b1, 3'd2, 8'h00, 8'h07},
    {1'b0, 1'b0, 3'd0, 8'h00, 8'h21},
    {1'b0, 1'b0, 3'd2, 8'h00, 8'hC2},
    {1'b1, 1'b1, 3'd3, 8'h03, 8'h00},
    {1'b0, 1'b1, 3'd1, 8'h00, 8'h0F},
    {1'b0, 1'b1, 3'd0, 8'h00, 8'h11},
    {1'b0, 1'b1, 3'd2, 8'h00, 8'hC1},
    {1'b0, 1'b1, 3'd5, 8'h00, 8'h60},
    {1'b0, 1'b1, 3'd6, 8'h00, 8'h30},
    {1'b0, 1'b0, 3'd5, 8'h00, 8'h61},
    {1'b0, 1'b0, 3'd6, 8'h00, 8'h31},
    {1'b1, 1'b0, 3'd4, 8'h1B, 8'h00},
    {1'b0, 1'b0, 3'd4, 8'h00, 8'h1B},
    {1'b0, 1'b1, 3'd4, 8'h00, 8'h00},
    {1'b0, 1'b1, 3'd3, 8'h00, 8'h03}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    logic on, off;

    repeat (5) @(negedge clk);
    // R1: outputs while in reset
    chk("R1 lcr", lcr_o, 16'h0);
    chk("R1 dll", dll_o, 16'h0);
    chk("R1 oe", data_oe, 1'b0);
    chk("R1 thr", thr_wr_o, 2'b00);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // Table walk: R2 R3 R4 R5 R8
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) begin
        bus_write(VEC[i][19], VEC[i][18:16], VEC[i][15:8], 1'b1, 3);
      end else begin
        bus_read(VEC[i][19], VEC[i][18:16], 1'b1, v, on, off);
        chk($sformatf("R8 R5 vec %0d data", i), v, VEC[i][7:0]);
        chk($sformatf("R8 vec %0d oe on", i), on, 1'b1);
        chk($sformatf("R8 vec %0d oe off", i), off, 1'b0);
      end
    end

    // R3: stored values on outputs, FIFO-control write
    chk("R3 ier bank0", ier_o[0], 8'h0F);
    chk("R3 mcr bank1", mcr_o[1], 8'h1B);
    bus_write(1'b1, 3'd2, 8'hC7, 1'b1, 3);
    chk("R3 fcr bank0", fcr_o[0], 8'hC7);
    chk("R2 fcr bank1", fcr_o[1], 8'h00);
    chk("R2 ier bank1", ier_o[1], 8'h00);

    // R4: divisor and alternate function bytes
    chk("R4 dll", dll_o[0], 8'h34);
    chk("R4 dlm", dlm_o[0], 8'h12);
    chk("R4 afr", afr_o[0], 8'h07);
    chk("R4 afr bank1", afr_o[1], 8'h00);

    // R6: long strobe, no early commit
    @(negedge clk);
    cs_n = 1'b0; ch_sel = 1'b0; addr_i = 3'd3; data_i = 8'h55;
    repeat (2) @(negedge clk);
    wr_n = 1'b0;
    repeat (12) @(negedge clk);
    chk("R6 hold", lcr_o[1], 8'h00);
    wr_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 commit", lcr_o[1], 8'h55);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7: chip select high
    bus_write(1'b1, 3'd7, 8'hFF, 1'b0, 3);
    bus_read(1'b1, 3'd7, 1'b1, v, on, off);
    chk("R7 write ignored", v, 8'hA5);
    bus_read(1'b1, 3'd7, 1'b0, v, on, off);
    chk("R7 read no drive", on, 1'b0);

    // R9: transmit pulse
    bus_write(1'b0, 3'd0, 8'h77, 1'b1, 3);
    chk("R9 pulse bank1", thr_cnt1, 1);
    chk("R9 no pulse bank0", thr_cnt0, 0);
    chk("R9 data bank1", thr_data_o[1], 8'h77);
    bus_write(1'b1, 3'd3, 8'h80, 1'b1, 3);
    bus_write(1'b1, 3'd0, 8'h99, 1'b1, 3);
    chk("R9 flag set no pulse", thr_cnt0, 0);
    chk("R4 dll rewrite", dll_o[0], 8'h99);

    // R10: chip select low, read strobe high
    @(negedge clk);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10 oe", data_oe, 1'b0);
    cs_n = 1'b1;

    // R1: reset again clears state
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 lcr after reset", lcr_o, 16'h0);
    chk("R1 dll after reset", dll_o[0], 8'h00);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule